// File: doc/BRIEF.md
# EPROM Pulse Programming Sequencer

This block writes a block of bytes from a source memory into a byte-wide, erasable, one-time-per-bit programmable memory device. It drives the device address, the write data, the active-low chip enable and output enable strobes, and two request flags that ask the board supply logic for the raised programming voltage and the raised core supply. It also reads the device data lines back to check each byte. It does not switch any supply itself.

The flow has three phases. First comes a blind pass that applies exactly one program pulse to every byte, lowest address first, with no read-back. Then an interactive pass starts again at address zero. It reads each byte back and, on a mismatch, applies one more pulse and reads again. A byte that still mismatches on its tenth read fails the device. Last, both supply requests drop to nominal and every byte is compared once more against the source. All timing is counted in clock cycles: every microsecond figure is multiplied by the parameter `CLK_PER_US`. The source port is a plain asynchronous read, with `src_data` following `src_addr` in the same cycle. Control and status pins are plain levels, so there is no handshake and no back-pressure anywhere on the block.

Software pulses `start` for one cycle. It then waits for `busy` to fall, and reads `done_pass`, or `done_fail` together with `fail_addr` and `fail_phase`.

Top module: `pgm_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy` is low, `ep_ce_n` and `ep_oe_n` are high, `ep_dq_oe` is low, both supply requests are low, and both verdict flags are low.
- R2: A `start` seen while idle raises `vpp_req` and `vcc_req` and begins the blind pass. This pass pulses each address once in ascending order from 0. `ep_oe_n` stays high for the whole pass, and both requests are high during every pulse.
- R3: A program pulse holds `ep_ce_n` low for exactly `PULSE_US*CLK_PER_US` cycles. During the pulse `ep_oe_n` is high, `ep_dq_oe` is high and `ep_dq_out` carries the source byte of the current address. `PULSE_US` is meant to lie between 95 and 105.
- R4: Address, data, the data drive enable, `ep_oe_n` and both requests are unchanged for at least `SETUP_US*CLK_PER_US` cycles before `ep_ce_n` falls for a pulse. They also stay unchanged for at least `HOLD_US*CLK_PER_US` cycles after it rises.
- R5: Each interactive read-back holds `ep_ce_n` high and `ep_oe_n` low with `ep_dq_oe` low. It samples `ep_dq_in` `RD_LAT` cycles after `ep_oe_n` falls. A match moves to the next address, and a match at the last address ends the pass.
- R6: On a read-back mismatch the block raises `ep_oe_n`, applies one more pulse and reads again. The `MAX_TRIES`-th mismatching read at one address ends the run with `done_fail`, `fail_addr` set to that address and `fail_phase` = 2'b01 (interactive). At most `MAX_TRIES-1` extra pulses are spent on any one address.
- R7: The retry count restarts from zero at each new address. Neighbouring bytes that each need up to `MAX_TRIES-1` extra pulses therefore all pass.
- R8: The final pass drops both requests and waits `SETUP_US*CLK_PER_US` cycles. It then reads every address with `ep_ce_n` and `ep_oe_n` both low, sampling `RD_LAT` cycles after the strobe falls. The first mismatch ends the run with `done_fail`, `fail_addr` and `fail_phase` = 2'b10 (final). If no byte mismatches, the run ends with `done_pass`.
- R9: `busy` is high from the cycle after `start` is taken until the verdict. `start` clears the verdict flags. The verdict, `fail_addr` and `fail_phase` hold until the next `start`, and `done_pass` and `done_fail` are never high together.
- R10: `start` is ignored while `busy` is high. The run in progress keeps its address sequence and its pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a programming run |
| busy | output | 1 | Run in progress |
| done_pass | output | 1 | Last run completed and every byte matched |
| done_fail | output | 1 | Last run stopped on a failing byte |
| fail_addr | output | $clog2(NUM_BYTES) | Address of the failing byte |
| fail_phase | output | 2 | 01 interactive pass, 10 final pass, 00 none |
| src_addr | output | $clog2(NUM_BYTES) | Source memory read address |
| src_data | input | DW | Source byte, valid in the same cycle as src_addr |
| ep_addr | output | $clog2(NUM_BYTES) | Device address |
| ep_dq_out | output | DW | Data driven toward the device |
| ep_dq_oe | output | 1 | Enables the board driver for ep_dq_out |
| ep_dq_in | input | DW | Data read from the device |
| ep_ce_n | output | 1 | Device chip enable, active low |
| ep_oe_n | output | 1 | Device output enable, active low |
| vpp_req | output | 1 | Request for the raised programming voltage |
| vcc_req | output | 1 | Request for the raised core supply |

## Verification
- `busy` rises and the verdict clears on the first cycle after the `start` edge.
- A pulse's chip enable falls exactly `SETUP_US*CLK_PER_US` cycles after the address or strobe change that opened its setup window.
- A read-back decides its byte from data sampled on cycle `RD_LAT` after `ep_oe_n` falls. The device model in the bench drives all-ones before that cycle, so an early sample shows up as an extra pulse.
- The verdict and the failing address appear on the cycle after the deciding sample.

The bench samples every output on the falling clock edge. It measures pulse widths and setup and hold windows by counting those samples. At each fall of `busy` it compares the verdict and the total pulse count against values worked out beforehand from the per-byte pulse needs.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SETTLE = 3'd1,
    S_PSETUP = 3'd2,
    S_PULSE  = 3'd3,
    S_PHOLD  = 3'd4,
    S_VERIFY = 3'd5,
    S_FREAD  = 3'd6
  } st_e;

  typedef enum logic [1:0] {
    PH_BLIND = 2'd0,
    PH_INTER = 2'd1,
    PH_FINAL = 2'd2
  } ph_e;

  localparam logic [1:0] FAILPH_NONE  = 2'b00;
  localparam logic [1:0] FAILPH_INTER = 2'b01;
  localparam logic [1:0] FAILPH_FINAL = 2'b10;
endpackage

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a loaded count runs down one step per cycle
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/pgm_try_ctr.sv
module pgm_try_ctr #(
  parameter int MAX_TRIES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] LAST_V = TW'(MAX_TRIES - 1);

  logic [TW-1:0] tries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries_q <= '0;
    else if (clr)   tries_q <= '0;
    else if (inc)   tries_q <= tries_q + 1'b1;
  end

  assign at_last = (tries_q == LAST_V);

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= LAST_V); // R6
  AST_NO_INC_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_last); // R6
endmodule

// File: rtl/pgm_fsm.sv
module pgm_fsm
  import pgm_pkg::*;
#(
  parameter int AW        = 4,
  parameter int TMR_W     = 8,
  parameter int LAST_ADDR = 15,
  parameter int PULSE_CYC = 400,
  parameter int SETUP_CYC = 8,
  parameter int HOLD_CYC  = 8,
  parameter int RD_LAT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_exp,
  input  logic             try_last,
  input  logic             byte_ok,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             try_clr,
  output logic             try_inc,
  output st_e              state,
  output ph_e              phase,
  output logic [AW-1:0]    addr,
  output logic             busy,
  output logic             done_pass,
  output logic             done_fail,
  output logic [AW-1:0]    fail_addr,
  output logic [1:0]       fail_phase
);
  localparam logic [AW-1:0]    LAST_A  = AW'(LAST_ADDR);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] T_READ  = TMR_W'(RD_LAT);

  st_e        nxt;
  ph_e        ph_nxt;
  logic       addr_clr, addr_inc;
  logic       set_pass, set_fail, clr_flags;
  logic [1:0] fph;
  logic       at_last_addr;

  assign at_last_addr = (addr == LAST_A);

  always_comb begin
    nxt       = state;
    ph_nxt    = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    set_pass  = 1'b0;
    set_fail  = 1'b0;
    clr_flags = 1'b0;
    fph       = FAILPH_NONE;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          nxt       = S_SETTLE;
          ph_nxt    = PH_BLIND;
          tmr_load  = 1'b1;
          tmr_val   = T_SETUP;
          addr_clr  = 1'b1;
          try_clr   = 1'b1;
          clr_flags = 1'b1;
        end
      end
      S_SETTLE: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (phase == PH_FINAL) begin
            nxt     = S_FREAD;
            tmr_val = T_READ;
          end else begin
            nxt     = S_PSETUP;
            tmr_val = T_SETUP;
          end
        end
      end
      S_PSETUP: begin
        if (tmr_exp) begin
          nxt      = S_PULSE;
          tmr_load = 1'b1;
          tmr_val  = T_PULSE;
        end
      end
      S_PULSE: begin
        if (tmr_exp) begin
          nxt      = S_PHOLD;
          tmr_load = 1'b1;
          tmr_val  = T_HOLD;
        end
      end
      S_PHOLD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (phase == PH_BLIND && !at_last_addr) begin
            nxt      = S_PSETUP;
            tmr_val  = T_SETUP;
            addr_inc = 1'b1;
          end else begin
            nxt     = S_VERIFY;
            tmr_val = T_READ;
            if (phase == PH_BLIND) begin
              ph_nxt   = PH_INTER;
              addr_clr = 1'b1;
              try_clr  = 1'b1;
            end
          end
        end
      end
      S_VERIFY: begin
        if (tmr_exp) begin
          if (byte_ok) begin
            tmr_load = 1'b1;
            try_clr  = 1'b1;
            if (at_last_addr) begin
              nxt      = S_SETTLE;
              ph_nxt   = PH_FINAL;
              tmr_val  = T_SETUP;
              addr_clr = 1'b1;
            end else begin
              tmr_val  = T_READ;
              addr_inc = 1'b1;
            end
          end else if (try_last) begin
            nxt      = S_IDLE;
            set_fail = 1'b1;
            fph      = FAILPH_INTER;
          end else begin
            nxt      = S_PSETUP;
            tmr_load = 1'b1;
            tmr_val  = T_SETUP;
            try_inc  = 1'b1;
          end
        end
      end
      S_FREAD: begin
        if (tmr_exp) begin
          if (!byte_ok) begin
            nxt      = S_IDLE;
            set_fail = 1'b1;
            fph      = FAILPH_FINAL;
          end else if (at_last_addr) begin
            nxt      = S_IDLE;
            set_pass = 1'b1;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = T_READ;
            addr_inc = 1'b1;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      phase      <= PH_BLIND;
      addr       <= '0;
      done_pass  <= 1'b0;
      done_fail  <= 1'b0;
      fail_addr  <= '0;
      fail_phase <= FAILPH_NONE;
    end else begin
      state <= nxt;
      phase <= ph_nxt;
      if (addr_clr)      addr <= '0;
      else if (addr_inc) addr <= addr + 1'b1;
      if (clr_flags) begin
        done_pass  <= 1'b0;
        done_fail  <= 1'b0;
        fail_addr  <= '0;
        fail_phase <= FAILPH_NONE;
      end else if (set_pass) begin
        done_pass <= 1'b1;
      end else if (set_fail) begin
        done_fail  <= 1'b1;
        fail_addr  <= addr;
        fail_phase <= fph;
      end
    end
  end

  assign busy = (state != S_IDLE);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pass && done_fail)); // R9
  AST_NO_VERDICT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done_pass && !done_fail)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_IDLE) |=> (phase == $past(phase) || phase != PH_BLIND)); // R10
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_pkg::*;
#(
  parameter int NUM_BYTES  = 16,
  parameter int DW         = 8,
  parameter int CLK_PER_US = 4,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int MAX_TRIES  = 10,
  parameter int RD_LAT     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         busy,
  output logic                         done_pass,
  output logic                         done_fail,
  output logic [$clog2(NUM_BYTES)-1:0] fail_addr,
  output logic [1:0]                   fail_phase,
  output logic [$clog2(NUM_BYTES)-1:0] src_addr,
  input  logic [DW-1:0]                src_data,
  output logic [$clog2(NUM_BYTES)-1:0] ep_addr,
  output logic [DW-1:0]                ep_dq_out,
  output logic                         ep_dq_oe,
  input  logic [DW-1:0]                ep_dq_in,
  output logic                         ep_ce_n,
  output logic                         ep_oe_n,
  output logic                         vpp_req,
  output logic                         vcc_req
);
  localparam int AW        = $clog2(NUM_BYTES);
  localparam int PULSE_CYC = PULSE_US * CLK_PER_US;
  localparam int SETUP_CYC = SETUP_US * CLK_PER_US;
  localparam int HOLD_CYC  = HOLD_US * CLK_PER_US;
  localparam int M1        = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int M2        = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
  localparam int MAXC      = (M2 > RD_LAT) ? M2 : RD_LAT;
  localparam int TMR_W     = $clog2(MAXC + 1);
  localparam int RW        = TMR_W + 1;
  localparam int SNAP_W    = AW + DW + 4;

  st_e             state;
  ph_e             phase;
  logic [AW-1:0]   addr;
  logic            tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic            try_clr, try_inc, try_last;
  logic            byte_ok;

  pgm_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  pgm_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .at_last(try_last)
  );

  pgm_fsm #(
    .AW(AW), .TMR_W(TMR_W), .LAST_ADDR(NUM_BYTES - 1), .PULSE_CYC(PULSE_CYC),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .RD_LAT(RD_LAT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_exp(tmr_exp), .try_last(try_last),
    .byte_ok(byte_ok), .tmr_load(tmr_load), .tmr_val(tmr_val), .try_clr(try_clr),
    .try_inc(try_inc), .state(state), .phase(phase), .addr(addr), .busy(busy),
    .done_pass(done_pass), .done_fail(done_fail), .fail_addr(fail_addr),
    .fail_phase(fail_phase)
  );

  assign byte_ok   = (ep_dq_in == src_data);
  assign src_addr  = addr;
  assign ep_addr   = addr;
  assign ep_dq_out = src_data;
  assign vpp_req   = busy && (phase != PH_FINAL);
  assign vcc_req   = busy && (phase != PH_FINAL);

  always_comb begin
    ep_ce_n  = 1'b1;
    ep_oe_n  = 1'b1;
    ep_dq_oe = 1'b0;
    unique case (state)
      S_PSETUP, S_PHOLD: ep_dq_oe = 1'b1;
      S_PULSE: begin
        ep_ce_n  = 1'b0;
        ep_dq_oe = 1'b1;
      end
      S_VERIFY: ep_oe_n = 1'b0;
      S_FREAD: begin
        ep_ce_n = 1'b0;
        ep_oe_n = 1'b0;
      end
      default: ;
    endcase
  end

  // window trackers for the timing properties below
  localparam logic [RW-1:0] PULSE_CHK = RW'(PULSE_CYC);
  localparam logic [RW-1:0] SETUP_CHK = RW'(SETUP_CYC);
  localparam logic [RW-1:0] HOLD_CHK  = RW'(HOLD_CYC);

  logic [SNAP_W-1:0] snap, snap_q;
  logic              chg;
  logic [RW-1:0]     low_run_q, stable_q, high_run_q;

  assign snap = {ep_addr, ep_dq_out, ep_dq_oe, ep_oe_n, vpp_req, vcc_req};
  assign chg  = (snap != snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= {{(AW + DW + 1){1'b0}}, 1'b1, 2'b00};
      low_run_q  <= '0;
      stable_q   <= '1;
      high_run_q <= '1;
    end else begin
      snap_q     <= snap;
      low_run_q  <= ep_ce_n ? '0 : low_run_q + 1'b1;
      stable_q   <= chg ? RW'(1) : ((stable_q == '1) ? stable_q : stable_q + 1'b1);
      high_run_q <= !ep_ce_n ? '0 : ((high_run_q == '1) ? high_run_q : high_run_q + 1'b1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ep_ce_n && ep_oe_n && !ep_dq_oe && !vpp_req && !vcc_req)); // R1
  AST_PULSE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_ce_n && vpp_req) |-> (ep_oe_n && ep_dq_oe && vcc_req)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ep_ce_n) && $past(vpp_req)) |-> (low_run_q == PULSE_CHK)); // R3
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ep_ce_n) && vpp_req) |-> (stable_q >= SETUP_CHK && !chg)); // R4
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && vpp_req) |-> (high_run_q >= HOLD_CHK)); // R4
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_oe_n |-> !ep_dq_oe); // R5
  AST_FINAL_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_ce_n && !ep_oe_n) |-> (!vpp_req && !vcc_req)); // R8
endmodule

// File: tb/tb_pgm_seq.sv
module tb_pgm_seq;
  localparam int NB   = 8;
  localparam int DW   = 8;
  localparam int CPU  = 2;
  localparam int RDL  = 2;
  localparam int MAXT = 10;
  localparam int PCYC = 100 * CPU;
  localparam int SCYC = 2 * CPU;
  localparam int HCYC = 2 * CPU;
  localparam int AW   = $clog2(NB);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start;
  logic          busy, done_pass, done_fail;
  logic [AW-1:0] fail_addr, src_addr, ep_addr;
  logic [1:0]    fail_phase;
  logic [DW-1:0] src_data, ep_dq_out, ep_dq_in;
  logic          ep_dq_oe, ep_ce_n, ep_oe_n, vpp_req, vcc_req;

  pgm_seq #(.NUM_BYTES(NB), .DW(DW), .CLK_PER_US(CPU), .MAX_TRIES(MAXT), .RD_LAT(RDL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done_pass(done_pass),
    .done_fail(done_fail), .fail_addr(fail_addr), .fail_phase(fail_phase),
    .src_addr(src_addr), .src_data(src_data), .ep_addr(ep_addr), .ep_dq_out(ep_dq_out),
    .ep_dq_oe(ep_dq_oe), .ep_dq_in(ep_dq_in), .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n),
    .vpp_req(vpp_req), .vcc_req(vcc_req)
  );

  // source memory and device model
  logic [DW-1:0] srcm [NB];
  logic [DW-1:0] mem  [NB];
  int            need [NB];
  int            pcnt [NB];
  bit            marg [NB];
  int            oe_age;

  assign src_data = srcm[src_addr];
  assign ep_dq_in = (!ep_oe_n && oe_age >= RDL)
                    ? (mem[ep_addr] ^ ((marg[ep_addr] && !vpp_req) ? 8'h01 : 8'h00))
                    : 8'hFF;

  always @(posedge clk) oe_age <= ep_oe_n ? 0 : oe_age + 1;

  int nvec = 0, nbad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  typedef struct { bit pass; int fa; int fph; int pulses; } exp_t;
  exp_t exp_q [$];

  // per-run observation counters
  int pulses, pw, run, hc;
  int pw_bad, setup_bad, hold_bad, ord_bad, blind_bad, bus_bad, ver_bad, fin_bad, req_bad;
  logic [AW+DW+3:0] snap, snap_q;
  logic ce_q = 1'b1, busy_q = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit chg;
      snap = {ep_addr, ep_dq_out, ep_dq_oe, ep_oe_n, vpp_req, vcc_req};
      chg  = (snap != snap_q);
      if (!ep_ce_n && ce_q && vpp_req) begin
        if (run < SCYC || chg) setup_bad++;
        pw = 0;
      end
      if (!ep_ce_n && vpp_req) begin
        pw++;
        if (!ep_oe_n || !ep_dq_oe || !vcc_req) req_bad++;
      end
      if (ep_ce_n && !ce_q && vpp_req) begin
        int a;
        a = int'(ep_addr);
        if (pw != PCYC) pw_bad++;
        pcnt[a]++;
        pulses++;
        if (pulses <= NB && a != pulses - 1) ord_bad++;
        if (pcnt[a] >= need[a]) mem[a] = mem[a] & ep_dq_out;
      end
      if (ep_ce_n) hc = (!ce_q) ? 0 : hc + 1;
      if (chg && vpp_req && hc < HCYC) hold_bad++;
      run = chg ? 1 : run + 1;
      snap_q = snap;
      if (!ep_oe_n && busy && pulses < NB) blind_bad++;
      if (!ep_oe_n && ep_dq_oe) bus_bad++;
      if (!ep_oe_n && vpp_req && !ep_ce_n) ver_bad++;
      if (!ep_ce_n && !ep_oe_n && (vpp_req || vcc_req)) fin_bad++;
      ce_q = ep_ce_n;
    end
  end

  // monitor: compare each verdict with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_q && !busy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 completion with nothing expected", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(done_pass == e.pass, "R8 pass verdict", int'(done_pass), int'(e.pass));
          chk(done_fail == !e.pass, "R6 fail verdict", int'(done_fail), int'(!e.pass));
          if (!e.pass) begin
            chk(int'(fail_addr) == e.fa, (e.fph == 1) ? "R6 fail address" : "R8 fail address",
                int'(fail_addr), e.fa);
            chk(int'(fail_phase) == e.fph, (e.fph == 1) ? "R6 fail phase" : "R8 fail phase",
                int'(fail_phase), e.fph);
          end
          chk(pulses == e.pulses, "R7 R10 total program pulses", pulses, e.pulses);
          chk(pw_bad == 0, "R3 pulse width", pw_bad, 0);
          chk(req_bad == 0, "R3 pulse strobes and requests", req_bad, 0);
          chk(setup_bad == 0, "R4 setup window", setup_bad, 0);
          chk(hold_bad == 0, "R4 hold window", hold_bad, 0);
          chk(ord_bad == 0, "R2 blind pass order", ord_bad, 0);
          chk(blind_bad == 0, "R2 no read-back in blind pass", blind_bad, 0);
          chk(bus_bad == 0 && ver_bad == 0, "R5 read-back bus state", bus_bad + ver_bad, 0);
          chk(fin_bad == 0, "R8 nominal supply on final reads", fin_bad, 0);
        end
      end
      busy_q = busy;
    end
  end

  // driver: compute the expected outcome, push it, launch the run
  task automatic run_case(input int marg_at, input int seed, input bit poke);
    exp_t e;
    e.pass = 1'b1; e.fa = 0; e.fph = 0; e.pulses = NB;
    for (int a = 0; a < NB; a++) begin
      if (need[a] - 1 <= MAXT - 1) begin
        e.pulses += need[a] - 1;
      end else begin
        e.pulses += MAXT - 1;
        e.pass = 1'b0; e.fa = a; e.fph = 1;
        break;
      end
    end
    if (e.pass && marg_at >= 0) begin
      e.pass = 1'b0; e.fa = marg_at; e.fph = 2;
    end
    for (int a = 0; a < NB; a++) begin
      srcm[a] = DW'((a * 29 + seed) & 8'h7F);
      mem[a]  = 8'hFF;
      pcnt[a] = 0;
      marg[a] = (a == marg_at);
    end
    pulses = 0; pw = 0; run = 0; hc = 1000;
    pw_bad = 0; setup_bad = 0; hold_bad = 0; ord_bad = 0; blind_bad = 0;
    bus_bad = 0; ver_bad = 0; fin_bad = 0; req_bad = 0;
    exp_q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    chk(busy && !done_pass && !done_fail, "R9 start raises busy and clears verdict",
        int'(busy) * 4 + int'(done_pass) * 2 + int'(done_fail), 4);
    chk(vpp_req && vcc_req, "R2 requests raised at start", int'(vpp_req) + int'(vcc_req), 2);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;              // R10: must be ignored
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    snap_q = '0;
    for (int a = 0; a < NB; a++) begin
      srcm[a] = '0; mem[a] = 8'hFF; need[a] = 1; pcnt[a] = 0; marg[a] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && ep_ce_n && ep_oe_n && !ep_dq_oe, "R1 strobes idle in reset",
        int'(busy) * 8 + int'(ep_ce_n) * 4 + int'(ep_oe_n) * 2 + int'(ep_dq_oe), 6);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!vpp_req && !vcc_req, "R1 supply requests low when idle",
        int'(vpp_req) + int'(vcc_req), 0);
    chk(!done_pass && !done_fail && !busy, "R1 no verdict after reset",
        int'(done_pass) + int'(done_fail) + int'(busy), 0);

    // every byte takes on its first pulse, with a start poked mid-run (R10)
    for (int a = 0; a < NB; a++) need[a] = 1;
    run_case(-1, 3, 1'b1);

    // mixed pulse needs, neighbours at the retry ceiling (R6, R7)
    need = '{1, 3, 10, 9, 1, 2, 1, 5};
    run_case(-1, 17, 1'b0);

    // address 5 never takes: interactive failure (R6)
    need = '{1, 2, 1, 1, 1, 11, 1, 1};
    run_case(-1, 40, 1'b0);
    repeat (50) @(negedge clk);
    chk(done_fail && !busy && fail_addr == 3'd5 && fail_phase == 2'b01,
        "R9 failure report held while idle", int'(fail_addr), 5);

    // byte 6 reads wrong only at nominal supply: final-pass failure (R8)
    for (int a = 0; a < NB; a++) need[a] = 1;
    run_case(6, 90, 1'b0);

    // every byte needs the most pulses still allowed (R7)
    for (int a = 0; a < NB; a++) need[a] = 10;
    run_case(-1, 55, 1'b0);
    chk(done_pass && !done_fail, "R9 pass verdict held", int'(done_pass), 1);

    chk(exp_q.size() == 0, "R9 every run reached a verdict", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule